// File: doc/BRIEF.md
# SPI Controller with Bus Registers and Serial CRC

This block is a register-driven SPI engine for a simple on-chip bus. Software programs a control register to pick master or slave operation, a power-of-two serial clock divider, an 8- or 16-bit frame, the bit order and the way the slave select is obtained. It then exchanges frames full duplex on a serial clock, a master-out line and a master-in line, using clock mode 0: output bits change after a falling clock edge and input bits are taken on the rising edge.

One bus address serves as the data port. A write fills the transmit buffer, and a read returns the separate receive buffer. Status flags tell software that the transmit buffer may be refilled, that a received frame is waiting, or that a frame was lost. Each flag can be routed to a single interrupt line. Two CRC accumulators, one for each direction, fold every bit into a running remainder, in the order the bits travel. The divisor polynomial is programmable.

In slave mode the incoming serial clock and select are passed through a two-stage synchronizer before their edges are detected. The bus clock must therefore run well above the serial clock.

Top module: `spic_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the interrupt-enable register (address 1) reads 0, the polynomial register (address 4) reads 0x0007, both CRC registers (address 5 receive, address 6 transmit) read 0, and the status register (address 2) reads 0x0002. In the status register, bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is overrun and bit 3 is busy. After reset `sck_o` is 0, `ss_n_o` is 1 and `irq` is 0.
- R2: The enable bit is control bit 4. While it is 0, no frame starts, `sck_o` stays 0, and a data word written to address 3 stays pending with transmit-empty at 0.
- R3: The divider field is control bits [2:0], value B. In master mode the period of `sck_o` is 2^(B+1) bus clocks.
- R4: The master bit is control bit 3. With it set and the block enabled, a pending transmit word starts a frame and sets transmit-empty. At the end of the frame the received word is readable at address 3 and receive-full is set. Reading address 3 clears receive-full.
- R5: The bit-order bit is control bit 5. At 0 the most significant bit is sent first on `mosi_o`; at 1 the least significant bit is sent first. The received word is assembled in the same order.
- R6: The width bit is control bit 6. At 0 a frame is 8 bits and at 1 it is 16 bits, both for the serial clock count and for the data.
- R7: In slave mode, with the select taken from the pin (control bit 7 at 0), a frame is clocked by `sck_i` while `ss_n_i` is low. The slave samples `mosi_i` on the rising edge and drives the transmit buffer on `miso_o`.
- R8: With control bit 7 set, the select comes from control bit 8 (0 = selected) and `ss_n_i` is ignored. While deselected, the slave neither receives a frame nor drives `miso_o`.
- R9: With control bit 9 set in master mode, `ss_n_o` is low for the whole of a frame and high between frames. In slave mode `ss_n_o` is always high.
- R10: `irq` is high when any of these holds: overrun with interrupt-enable bit 0, receive-full with bit 1, or transmit-empty with bit 2.
- R11: For each direction, the CRC register steps once per bit, in the order the bits travel. A step shifts left by one bit, and when the outgoing top bit (bit 7 for 8-bit frames, bit 15 for 16-bit frames) differs from the data bit, the result is XORed with the polynomial. In 8-bit frames the upper byte is kept at zero. Both CRC registers clear when the enable bit goes from 0 to 1.
- R12: A frame that ends while receive-full is set sets overrun and leaves the receive buffer unchanged. Overrun clears only on a data read that follows a status read which showed overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on status and data reads) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_i | input | 1 | Master data in |
| ss_n_o | output | 1 | Chip select out, active low |
| ss_n_i | input | 1 | Slave select in, active low |

## Verification
The checks assume that bus strobes are single-cycle and never hit the status and data addresses in the same cycle. They also assume that in slave mode the serial clock halves last several bus clocks longer than the synchronizer delay. The bench meets both: every register access is one strobe with an idle cycle after it, and its own serial master holds each clock phase for eight bus clocks, with data set up well before the rising edge. The overrun check leans on the rule that a status read shows overrun only once it is set. For that reason the bench waits a fixed time instead of polling status while the second frame is in flight.

// File: rtl/spic_pkg.sv
package spic_pkg;

    localparam int DW      = 16;
    localparam int HW      = DW / 2;
    localparam int AW      = 3;
    localparam int BAUD_W  = 3;
    localparam int CTRL_W  = 10;
    localparam int IRQ_W   = 3;

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_IRQEN = 3'd1;
    localparam logic [AW-1:0] A_STAT  = 3'd2;
    localparam logic [AW-1:0] A_DATA  = 3'd3;
    localparam logic [AW-1:0] A_POLY  = 3'd4;
    localparam logic [AW-1:0] A_RXCRC = 3'd5;
    localparam logic [AW-1:0] A_TXCRC = 3'd6;

    localparam logic [DW-1:0] POLY_RST = 16'h0007;

    typedef struct packed {
        logic              ss_oe;     // bit 9
        logic              ss_level;  // bit 8
        logic              ss_soft;   // bit 7
        logic              wide;      // bit 6
        logic              lsb_first; // bit 5
        logic              enable;    // bit 4
        logic              master;    // bit 3
        logic [BAUD_W-1:0] baud;      // bits 2:0
    } ctrl_t;

    typedef struct packed {
        logic txe_ie;  // bit 2
        logic rxne_ie; // bit 1
        logic err_ie;  // bit 0
    } irqen_t;

    typedef struct packed {
        logic busy;    // bit 3
        logic ovr;     // bit 2
        logic txe;     // bit 1
        logic rxne;    // bit 0
    } stat_t;

    // One bit-serial division step; narrow frames use the low half only.
    function automatic logic [DW-1:0] crc_step(input logic [DW-1:0] crc,
                                               input logic [DW-1:0] poly,
                                               input logic          din,
                                               input logic          wide);
        logic          fb;
        logic [DW-1:0] nx;
        fb = (wide ? crc[DW-1] : crc[HW-1]) ^ din;
        nx = {crc[DW-2:0], 1'b0} ^ (fb ? poly : '0);
        if (!wide) nx[DW-1:HW] = '0;
        return nx;
    endfunction

endpackage

// File: rtl/spic_sync.sv
module spic_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spic_clkdiv.sv
module spic_clkdiv #(
    parameter int BAUD_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BAUD_W-1:0] baud,
    output logic              sck,
    output logic              rise,
    output logic              fall
);
    localparam int CW = (1 << BAUD_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW:0]   half;
    logic [CW:0]   lim;
    logic          tick;

    assign half = (CW+1)'(1) << baud;
    assign lim  = half - (CW+1)'(1);
    assign tick = run && (cnt == lim[CW-1:0]);
    assign rise = tick && !sck;
    assign fall = tick && sck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= !sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spic_shifter.sv
module spic_shifter
    import spic_pkg::*;
#(
    parameter int CNTW = $clog2(DW + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            abort,
    input  logic            load,
    input  logic [DW-1:0]   load_data,
    input  logic            wide,
    input  logic            lsb_first,
    input  logic            end_on_fall,
    input  logic            rise,
    input  logic            fall,
    input  logic            in_bit,
    output logic            out_bit,
    output logic            active,
    output logic            done,
    output logic [DW-1:0]   rx_word,
    output logic [CNTW-1:0] bit_cnt
);
    logic [DW-1:0]   tx_sr, rx_sr, rx_shift, rx_src;
    logic [CNTW-1:0] nbits;

    assign nbits    = wide ? CNTW'(DW) : CNTW'(HW);
    assign out_bit  = lsb_first ? tx_sr[0] : (wide ? tx_sr[DW-1] : tx_sr[HW-1]);
    assign rx_shift = lsb_first ? {in_bit, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], in_bit};
    assign rx_src   = rise ? rx_shift : rx_sr;
    assign rx_word  = wide ? rx_src :
                      (lsb_first ? {{HW{1'b0}}, rx_src[DW-1:HW]} : {{HW{1'b0}}, rx_src[HW-1:0]});
    assign done     = active && (end_on_fall ? (fall && bit_cnt == nbits)
                                             : (rise && bit_cnt == nbits - 1'b1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (load) begin
            active  <= 1'b1;
            bit_cnt <= '0;
            tx_sr   <= wide ? load_data : {{HW{1'b0}}, load_data[HW-1:0]};
            rx_sr   <= '0;
        end else if (active) begin
            if (rise) begin
                rx_sr   <= rx_shift;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall && bit_cnt != '0 && bit_cnt != nbits)
                tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
            if (done) active <= 1'b0;
        end
    end
endmodule

// File: rtl/spic_crc.sv
module spic_crc
    import spic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic          din,
    input  logic          wide,
    input  logic [DW-1:0] poly,
    output logic [DW-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc <= '0;
        else if (step)    crc <= crc_step(crc, poly, din, wide);
    end
endmodule

// File: rtl/spic_ctrl.sv
module spic_ctrl
    import spic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          sck_o,
    input  logic          sck_i,
    output logic          mosi_o,
    input  logic          mosi_i,
    output logic          miso_o,
    input  logic          miso_i,
    output logic          ss_n_o,
    input  logic          ss_n_i
);
    localparam int CNTW = $clog2(DW + 1);

    ctrl_t         ctrl_q;
    irqen_t        irqen_q;
    stat_t         stat;
    logic [DW-1:0] poly_q, txbuf_q, rxbuf_q;
    logic          rxne_q, txe_q, ovr_q, ovr_armed_q, en_q, ss_n_q;

    logic          en_w, master_w, selected, load, abort, busy, frame_done;
    logic          data_rd, stat_rd, data_wr;
    logic          m_sck, m_rise, m_fall, s_rise, s_fall, rise, fall;
    logic          out_bit, in_bit;
    logic [1:0]    sync_q;
    logic          sck_s, ss_n_s, sck_prev;
    logic [DW-1:0] rx_word;
    logic [CNTW-1:0] bit_cnt;
    logic [DW-1:0] crc_q [2];

    assign en_w     = ctrl_q.enable;
    assign master_w = ctrl_q.master;
    assign data_rd  = bus_rd && bus_addr == A_DATA;
    assign stat_rd  = bus_rd && bus_addr == A_STAT;
    assign data_wr  = bus_wr && bus_addr == A_DATA;

    // Slave-side pin synchronization and edge detection.
    spic_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst(rst), .d({ss_n_i, sck_i}), .q(sync_q)
    );
    assign sck_s  = sync_q[0];
    assign ss_n_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b0;
        else     sck_prev <= sck_s;
    end
    assign s_rise = sck_s && !sck_prev;
    assign s_fall = !sck_s && sck_prev;

    // Master clock generation.
    spic_clkdiv #(.BAUD_W(BAUD_W)) u_div (
        .clk(clk), .rst(rst), .run(en_w && master_w && busy), .baud(ctrl_q.baud),
        .sck(m_sck), .rise(m_rise), .fall(m_fall)
    );

    assign selected = ctrl_q.ss_soft ? !ctrl_q.ss_level : !ss_n_s;
    assign load     = en_w && !busy && (master_w ? !txe_q : selected);
    assign abort    = !en_w || (!master_w && !selected);
    assign rise     = master_w ? m_rise : s_rise;
    assign fall     = master_w ? m_fall : s_fall;
    assign in_bit   = master_w ? miso_i : mosi_i;

    spic_shifter u_shift (
        .clk(clk), .rst(rst), .abort(abort), .load(load), .load_data(txbuf_q),
        .wide(ctrl_q.wide), .lsb_first(ctrl_q.lsb_first), .end_on_fall(master_w),
        .rise(rise), .fall(fall), .in_bit(in_bit), .out_bit(out_bit),
        .active(busy), .done(frame_done), .rx_word(rx_word), .bit_cnt(bit_cnt)
    );

    // CRC accumulators: index 0 follows sent bits, index 1 follows received bits.
    for (genvar g = 0; g < 2; g++) begin : g_crc
        spic_crc u_crc (
            .clk(clk), .rst(rst), .clear(en_w && !en_q), .step(busy && rise),
            .din(g == 0 ? out_bit : in_bit), .wide(ctrl_q.wide), .poly(poly_q),
            .crc(crc_q[g])
        );
    end

    assign sck_o  = m_sck;
    assign mosi_o = en_w && master_w && busy && out_bit;
    assign miso_o = en_w && !master_w && busy && out_bit;
    assign ss_n_o = ss_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            irqen_q     <= '0;
            poly_q      <= POLY_RST;
            txbuf_q     <= '0;
            rxbuf_q     <= '0;
            rxne_q      <= 1'b0;
            txe_q       <= 1'b1;
            ovr_q       <= 1'b0;
            ovr_armed_q <= 1'b0;
            en_q        <= 1'b0;
            ss_n_q      <= 1'b1;
        end else begin
            en_q   <= en_w;
            ss_n_q <= !(en_w && master_w && ctrl_q.ss_oe && (busy || load));
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL:  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    A_IRQEN: irqen_q <= irqen_t'(bus_wdata[IRQ_W-1:0]);
                    A_POLY:  poly_q  <= bus_wdata;
                    A_DATA:  txbuf_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (load)    txe_q <= 1'b1;
            if (data_wr) txe_q <= 1'b0;
            if (stat_rd) ovr_armed_q <= ovr_q;
            if (data_rd) begin
                rxne_q <= 1'b0;
                if (ovr_armed_q) begin
                    ovr_q       <= 1'b0;
                    ovr_armed_q <= 1'b0;
                end
            end
            if (frame_done) begin
                if (rxne_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    rxbuf_q <= rx_word;
                    rxne_q  <= 1'b1;
                end
            end
        end
    end

    assign stat = '{busy: busy, ovr: ovr_q, txe: txe_q, rxne: rxne_q};
    assign irq  = (irqen_q.err_ie && ovr_q) || (irqen_q.rxne_ie && rxne_q) ||
                  (irqen_q.txe_ie && txe_q);

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            A_IRQEN: bus_rdata = {{(DW-IRQ_W){1'b0}}, irqen_q};
            A_STAT:  bus_rdata = {{(DW-$bits(stat_t)){1'b0}}, stat};
            A_DATA:  bus_rdata = rxbuf_q;
            A_POLY:  bus_rdata = poly_q;
            A_RXCRC: bus_rdata = crc_q[1];
            A_TXCRC: bus_rdata = crc_q[0];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spic_ctrl_chk.sv
module spic_ctrl_chk
    import spic_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          en_w,
    input logic          master_w,
    input logic          sck_o,
    input logic          ss_n_o,
    input logic          frame_done,
    input logic          rxne,
    input logic          ovr,
    input logic          data_rd,
    input logic [DW-1:0] txcrc,
    input logic [DW-1:0] rxcrc,
    input logic [4:0]    bit_cnt,
    input logic [2:0]    irqen,
    input logic          irq
);
    a_r2_off_no_clock: assert property (@(posedge clk) disable iff (rst)
        !en_w |=> !sck_o);

    a_r4_done_sets_full: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> rxne);

    a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        ovr && !data_rd |=> ovr);

    a_r12_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        !ovr && !(frame_done && rxne) |=> !ovr);

    a_r9_slave_ss_high: assert property (@(posedge clk) disable iff (rst)
        !master_w |=> ss_n_o);

    a_r11_crc_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(en_w) |=> (txcrc == '0 && rxcrc == '0));

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
        irqen == 3'b000 |-> !irq);

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= 5'd16);
endmodule

bind spic_ctrl spic_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .en_w(en_w), .master_w(master_w), .sck_o(sck_o),
    .ss_n_o(ss_n_o), .frame_done(frame_done), .rxne(rxne_q), .ovr(ovr_q),
    .data_rd(data_rd), .txcrc(crc_q[0]), .rxcrc(crc_q[1]), .bit_cnt(bit_cnt),
    .irqen(irqen_q), .irq(irq)
);

// File: tb/spic_ctrl_test.sv
module spic_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, sck_o, mosi_o, miso_o, ss_n_o;
    logic        sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, lb_inv = 1'b0;
    logic        miso_i;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    assign miso_i = mosi_o ^ lb_inv;

    always #5 clk = ~clk;

    spic_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o),
        .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o),
        .miso_i(miso_i), .ss_n_o(ss_n_o), .ss_n_i(ss_n_i)
    );

    // Monitor of the master-side pins.
    logic [15:0] mon_sr = '0;
    int          mon_cnt = 0, ss_low_cnt = 0;
    longint      t_last = 0, t_prev = 0;
    always @(posedge sck_o) begin
        mon_sr     <= {mon_sr[14:0], mosi_o};
        mon_cnt    <= mon_cnt + 1;
        if (!ss_n_o) ss_low_cnt <= ss_low_cnt + 1;
        t_prev     <= t_last;
        t_last     <= $time;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_full();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(3'd2, s);
            if (s[0]) break;
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] poly,
                                            input logic [15:0] data, input bit wide, input bit lsb);
        int n = wide ? 16 : 8;
        for (int i = 0; i < n; i++) begin
            logic b, top;
            b   = lsb ? data[i] : data[n-1-i];
            top = wide ? c[15] : c[7];
            c   = {c[14:0], 1'b0} ^ ((top ^ b) ? poly : 16'h0);
            if (!wide) c[15:8] = 8'h00;
        end
        return c;
    endfunction

    logic [15:0] exp_tx = '0, exp_rx = '0;

    task automatic t_reset();
        logic [15:0] d;
        rd(3'd0, d); check(d == 16'h0000, "R1 ctrl reset", d, 16'h0000);
        rd(3'd1, d); check(d == 16'h0000, "R1 irqen reset", d, 16'h0000);
        rd(3'd4, d); check(d == 16'h0007, "R1 poly reset", d, 16'h0007);
        rd(3'd2, d); check(d == 16'h0002, "R1 status reset", d, 16'h0002);
        rd(3'd5, d); check(d == 16'h0000, "R1 rx crc reset", d, 16'h0000);
        rd(3'd6, d); check(d == 16'h0000, "R1 tx crc reset", d, 16'h0000);
        check(sck_o == 1'b0 && ss_n_o == 1'b1 && irq == 1'b0, "R1 pins reset",
              {sck_o, ss_n_o, irq}, 3'b010);
    endtask

    task automatic t_disabled();
        logic [15:0] d;
        int base = mon_cnt;
        wr(3'd0, 16'h0008);
        wr(3'd3, 16'h00A5);
        repeat (100) @(negedge clk);
        check(mon_cnt == base, "R2 no clock while disabled", mon_cnt - base, 0);
        rd(3'd2, d); check(d == 16'h0000, "R2 word stays pending", d, 16'h0000);
    endtask

    task automatic t_master8();
        logic [15:0] d;
        int base = mon_cnt;
        wr(3'd0, 16'h0018);
        exp_tx = '0; exp_rx = '0;
        wait_full();
        check(mon_cnt - base == 8, "R4 eight clocks", mon_cnt - base, 8);
        check(mon_sr[7:0] == 8'hA5, "R5 msb-first on mosi", mon_sr[7:0], 8'hA5);
        rd(3'd2, d); check(d[1:0] == 2'b11, "R4 flags after frame", d[1:0], 2'b11);
        rd(3'd3, d); check(d == 16'h00A5, "R4 loopback word", d, 16'h00A5);
        rd(3'd2, d); check(d[0] == 1'b0, "R4 read clears full", d[0], 0);
        exp_tx = crc_ref(exp_tx, 16'h0007, 16'h00A5, 0, 0);
        exp_rx = crc_ref(exp_rx, 16'h0007, 16'h00A5, 0, 0);
        rd(3'd6, d); check(d == exp_tx, "R11 tx crc", d, exp_tx);
        rd(3'd5, d); check(d == exp_rx, "R11 rx crc", d, exp_rx);
    endtask

    task automatic t_invert();
        logic [15:0] d;
        lb_inv = 1'b1;
        wr(3'd3, 16'h003C);
        wait_full();
        rd(3'd3, d); check(d == 16'h00C3, "R4 inverted return", d, 16'h00C3);
        exp_tx = crc_ref(exp_tx, 16'h0007, 16'h003C, 0, 0);
        exp_rx = crc_ref(exp_rx, 16'h0007, 16'h00C3, 0, 0);
        rd(3'd6, d); check(d == exp_tx, "R11 tx crc second frame", d, exp_tx);
        rd(3'd5, d); check(d == exp_rx, "R11 rx crc differs", d, exp_rx);
        lb_inv = 1'b0;
    endtask

    task automatic t_lsb();
        logic [15:0] d;
        wr(3'd0, 16'h0038);
        wr(3'd3, 16'h0001);
        wait_full();
        check(mon_sr[7:0] == 8'h80, "R5 lsb-first on mosi", mon_sr[7:0], 8'h80);
        rd(3'd3, d); check(d == 16'h0001, "R5 lsb-first receive", d, 16'h0001);
    endtask

    task automatic t_wide();
        logic [15:0] d;
        int base;
        wr(3'd0, 16'h0048);
        wr(3'd4, 16'h1021);
        base = mon_cnt;
        wr(3'd3, 16'hBEEF);
        wr(3'd0, 16'h0058);
        wait_full();
        check(mon_cnt - base == 16, "R6 sixteen clocks", mon_cnt - base, 16);
        check(mon_sr == 16'hBEEF, "R6 wide on mosi", mon_sr, 16'hBEEF);
        rd(3'd3, d); check(d == 16'hBEEF, "R6 wide receive", d, 16'hBEEF);
        exp_tx = crc_ref(16'h0, 16'h1021, 16'hBEEF, 1, 0);
        rd(3'd6, d); check(d == exp_tx, "R11 wide crc with new poly", d, exp_tx);
        wr(3'd0, 16'h0048);
        wr(3'd4, 16'h0007);
    endtask

    task automatic t_baud(input int b);
        logic [15:0] d;
        wr(3'd0, 16'h0008 | 16'(b));
        wr(3'd3, 16'h005A);
        wr(3'd0, 16'h0018 | 16'(b));
        wait_full();
        check((t_last - t_prev) == longint'((2 << b) * 10), "R3 sck period",
              t_last - t_prev, (2 << b) * 10);
        rd(3'd3, d);
    endtask

    task automatic t_ssout();
        logic [15:0] d;
        int base = ss_low_cnt, mbase = mon_cnt;
        wr(3'd0, 16'h0218);
        check(ss_n_o == 1'b1, "R9 high before frame", ss_n_o, 1);
        wr(3'd3, 16'h0066);
        wait_full();
        check(ss_low_cnt - base == mon_cnt - mbase, "R9 low at every edge",
              ss_low_cnt - base, mon_cnt - mbase);
        repeat (4) @(negedge clk);
        check(ss_n_o == 1'b1, "R9 high after frame", ss_n_o, 1);
        rd(3'd3, d);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        wr(3'd1, 16'h0004);
        @(negedge clk); check(irq == 1'b1, "R10 irq on tx empty", irq, 1);
        wr(3'd1, 16'h0002);
        @(negedge clk); check(irq == 1'b0, "R10 masked while not full", irq, 0);
        wr(3'd3, 16'h0033);
        wait_full();
        @(negedge clk); check(irq == 1'b1, "R10 irq on full", irq, 1);
        rd(3'd3, d);
        @(negedge clk); check(irq == 1'b0, "R10 drops after read", irq, 0);
    endtask

    task automatic t_overrun();
        logic [15:0] d;
        wr(3'd1, 16'h0001);
        wr(3'd3, 16'h0011);
        wait_full();
        wr(3'd3, 16'h0022);
        repeat (80) @(negedge clk);
        check(irq == 1'b1, "R12 overrun raises error irq", irq, 1);
        rd(3'd3, d); check(d == 16'h0011, "R12 buffer keeps first", d, 16'h0011);
        @(negedge clk); check(irq == 1'b1, "R12 data read alone keeps overrun", irq, 1);
        rd(3'd2, d); check(d == 16'h0006, "R12 status shows overrun", d, 16'h0006);
        rd(3'd3, d);
        rd(3'd2, d); check(d == 16'h0002, "R12 cleared by status then data", d, 16'h0002);
        wr(3'd1, 16'h0000);
    endtask

    task automatic slave_xfer(input logic [7:0] tx, input bit drive_ss, output logic [7:0] rx);
        if (drive_ss) ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = tx[i];
            repeat (8) @(negedge clk);
            rx[i] = miso_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_slave();
        logic [15:0] d;
        logic [7:0]  r;
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0010);
        wr(3'd3, 16'h0096);
        slave_xfer(8'h5A, 1, r);
        check(r == 8'h96, "R7 slave drives miso", r, 8'h96);
        rd(3'd3, d); check(d == 16'h005A, "R7 slave receives mosi", d, 16'h005A);
        check(ss_n_o == 1'b1, "R9 slave keeps ss out high", ss_n_o, 1);
    endtask

    task automatic t_softss();
        logic [15:0] d;
        logic [7:0]  r;
        wr(3'd0, 16'h0190);
        wr(3'd3, 16'h0069);
        slave_xfer(8'hFF, 1, r);
        check(r == 8'h00, "R8 deselected keeps miso low", r, 8'h00);
        rd(3'd2, d); check(d[0] == 1'b0, "R8 deselected ignores frame", d[0], 0);
        wr(3'd0, 16'h0090);
        slave_xfer(8'hC4, 0, r);
        check(r == 8'h69, "R8 soft select sends", r, 8'h69);
        rd(3'd3, d); check(d == 16'h00C4, "R8 pin ignored, frame received", d, 16'h00C4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_master8();
        t_invert();
        t_lsb();
        t_wide();
        t_baud(0);
        t_baud(3);
        t_baud(7);
        wr(3'd0, 16'h0008);
        t_ssout();
        wr(3'd0, 16'h0018);
        t_irq();
        t_overrun();
        t_slave();
        t_softss();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule